// File: doc/BRIEF.md
# Byte-Lane Bus Access Splitter

This block sits between a processor core and a 16-bit external data bus that carries a 20-bit byte address. The core asks for a byte or a 16-bit word, to read or to write. The block turns each request into one or two bus operations. Each byte goes out on the data lane that matches its address: the low lane is bits 7:0 and the high lane is bits 15:8. The block drives a strobe for each lane and puts read bytes back together into a little-endian result.

A word at an even address needs one bus operation that uses both lanes. A word at an odd address is split into two byte operations:

- The first carries the low byte, at the requested address, on the high lane.
- The second carries the high byte, at the next address, on the low lane.

The core holds its request until it sees a one-cycle acknowledge. Every bus operation keeps the bus busy for a fixed number of clock cycles, set by `BUS_LAT`. Read data is taken in on the last of those cycles.

Top module: `lane_split_bus`

## Requirements
- R1: While reset is asserted and while idle, `bus_cyc`, `bus_lo_en`, `bus_hi_en` and `req_ack` are 0 and `bus_wdata` is zero.
- R2: A byte request at an even address makes one bus operation at that address. Only `bus_lo_en` is 1, and the byte travels on bits 7:0.
- R3: A byte request at an odd address makes one bus operation at that address. Only `bus_hi_en` is 1, and the byte travels on bits 15:8. A byte read returns the byte in `req_rdata[7:0]` with bits 15:8 zero.
- R4: A word request at an even address A makes one bus operation with both enables at 1. The byte at A is bits 7:0 and the byte at A+1 is bits 15:8.
- R5: A word request at an odd address A makes two bus operations:
  - first at address A, with only `bus_hi_en`, carrying word bits 7:0 on bus bits 15:8;
  - then at A+1, with only `bus_lo_en`, carrying word bits 15:8 on bus bits 7:0.
- R6: The second address of a split word wraps modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R7: Each bus operation holds `bus_cyc` high for exactly `BUS_LAT` cycles. `req_ack` rises for exactly one cycle, in the cycle after the last bus operation ends, and never while `bus_cyc` is high.
- R8: On a write, the data bits of a lane whose enable is 0 are zero. On a read, `bus_wdata` is zero during the whole bus operation.
- R9: `bus_lo_en` is 1 during a bus operation exactly when `bus_addr[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address of the request |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read result, valid with `req_ack` |
| bus_cyc | output | 1 | High while a bus operation is in progress |
| bus_we | output | 1 | Bus operation is a write |
| bus_addr | output | 20 | Byte address of the bus operation |
| bus_lo_en | output | 1 | Low lane (bits 7:0) enable, active high |
| bus_hi_en | output | 1 | High lane (bits 15:8) enable, active high |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from memory, both lanes |

## Verification
The bench tries four request shapes:

- **Even byte and odd byte.** These show whether lane steering follows address bit 0.
- **Word at an even address.** This shows a single two-lane operation.
- **Word at an odd address.** Only this shape can expose a missing split, swapped byte order or a wrong second address.

A word at 0xFFFFF checks the address wrap. Random mixes of reads and writes over small address windows cause overlapping byte and word accesses. This checks that bytes written through one shape are read back correctly through another.

// File: rtl/lane_split_bus.sv
module lane_split_bus #(
  parameter int AW      = 20,
  parameter int BUS_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_ack,
  output logic [15:0]   req_rdata,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic          bus_lo_en,
  output logic          bus_hi_en,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata
);

  localparam int CW = (BUS_LAT > 1) ? $clog2(BUS_LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(BUS_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_ACK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          r_we, r_word;
  logic [AW-1:0] r_addr;
  logic [15:0]   r_wd, rd_acc;

  logic          split, in_bus, ph_word, last_beat;
  logic [AW-1:0] cur_addr;
  logic [7:0]    wbyte;

  assign split     = r_word & r_addr[0];
  assign in_bus    = (st == S_FIRST) || (st == S_SECOND);
  assign ph_word   = r_word & ~split;
  assign cur_addr  = (st == S_SECOND) ? r_addr + AW'(1) : r_addr;
  assign last_beat = (cnt == LAST);
  assign wbyte     = (st == S_SECOND) ? r_wd[15:8] : r_wd[7:0];

  assign bus_cyc   = in_bus;
  assign bus_we    = in_bus & r_we;
  assign bus_addr  = in_bus ? cur_addr : '0;
  assign bus_lo_en = in_bus & ~cur_addr[0];
  assign bus_hi_en = in_bus & (cur_addr[0] | ph_word);

  always_comb begin
    bus_wdata = '0;
    if (in_bus && r_we) begin
      if (ph_word)          bus_wdata = r_wd;
      else if (cur_addr[0]) bus_wdata = {wbyte, 8'h00};
      else                  bus_wdata = {8'h00, wbyte};
    end
  end

  assign req_ack   = (st == S_ACK);
  assign req_rdata = (st == S_ACK && !r_we) ? rd_acc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      r_we   <= 1'b0;
      r_word <= 1'b0;
      r_addr <= '0;
      r_wd   <= '0;
      rd_acc <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_we   <= req_write;
          r_word <= req_word;
          r_addr <= req_addr;
          r_wd   <= req_write ? req_wdata : 16'h0000;
          rd_acc <= '0;
          cnt    <= '0;
          st     <= S_FIRST;
        end
        S_FIRST: begin
          if (last_beat) begin
            if (ph_word)          rd_acc      <= bus_rdata;
            else if (cur_addr[0]) rd_acc[7:0] <= bus_rdata[15:8];
            else                  rd_acc[7:0] <= bus_rdata[7:0];
            cnt <= '0;
            st  <= split ? S_SECOND : S_ACK;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_SECOND: begin
          if (last_beat) begin
            rd_acc[15:8] <= bus_rdata[7:0];
            cnt <= '0;
            st  <= S_ACK;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_split_bus_chk.sv
module lane_split_bus_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ack,
  input logic          bus_cyc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_lo_en,
  input logic          bus_hi_en,
  input logic [15:0]   bus_wdata
);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R7
  ack_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ack);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (!bus_lo_en && !bus_hi_en && bus_wdata == 16'h0000));

  // R9
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_lo_en == !bus_addr[0]));

  // R8
  unused_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_hi_en) |-> (bus_wdata[15:8] == 8'h00));

  // R8
  unused_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_lo_en) |-> (bus_wdata[7:0] == 8'h00));

  // R8
  read_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_we) |-> (bus_wdata == 16'h0000));

  // R5
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc) && bus_addr != $past(bus_addr))
      |-> (bus_addr == $past(bus_addr) + AW'(1) && bus_lo_en && !bus_hi_en));

endmodule

bind lane_split_bus lane_split_bus_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .bus_cyc(bus_cyc),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_lo_en(bus_lo_en),
  .bus_hi_en(bus_hi_en), .bus_wdata(bus_wdata)
);

// File: tb/sim_lane_split_bus.sv
module sim_lane_split_bus;
  localparam int AW  = 20;
  localparam int LAT = 2;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ack, bus_cyc, bus_we, bus_lo_en, bus_hi_en;
  logic [15:0] req_rdata, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic [AW-1:0] bus_addr;

  always #10 clk = ~clk;

  lane_split_bus #(.AW(AW), .BUS_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_lo_en(bus_lo_en),
    .bus_hi_en(bus_hi_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int total = 0, bad = 0;
  logic [7:0] mem  [int];
  logic [7:0] refm [int];

  function automatic logic [7:0] seed_byte(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : seed_byte(a);
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return refm.exists(a) ? refm[a] : seed_byte(a);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) if (bus_cyc && bus_we) begin
    if (bus_lo_en) mem[int'({bus_addr[AW-1:1], 1'b0})] = bus_wdata[7:0];
    if (bus_hi_en) mem[int'({bus_addr[AW-1:1], 1'b1})] = bus_wdata[15:8];
  end

  int nph = 0, ncyc = 0;
  logic prev_cyc = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-1:0] ph_addr [2];
  logic ph_lo [2], ph_hi [2];
  logic [15:0] ph_wd [2];

  always @(negedge clk) begin
    bus_rdata = {mem_rd(int'({bus_addr[AW-1:1], 1'b1})),
                 mem_rd(int'({bus_addr[AW-1:1], 1'b0}))};
    if (bus_cyc) begin
      if (!prev_cyc || bus_addr != prev_addr) begin
        if (nph < 2) begin
          ph_addr[nph] = bus_addr; ph_lo[nph] = bus_lo_en;
          ph_hi[nph] = bus_hi_en;  ph_wd[nph] = bus_wdata;
        end
        nph++;
      end
      ncyc++;
    end
    prev_cyc = bus_cyc;
    prev_addr = bus_addr;
  end

  task automatic do_req(bit we, bit word, int a, logic [15:0] wd);
    bit odd = a[0];
    bit spl = word && odd;
    int ops = spl ? 2 : 1;
    int a1 = (a + 1) & AMASK;
    string rq;
    int k = 0;
    logic [15:0] got;
    logic [15:0] e_wd0, e_wd1, e_rd;
    if (spl) rq = (a == AMASK) ? "R6" : "R5";
    else if (word) rq = "R4";
    else rq = odd ? "R3" : "R2";
    nph = 0; ncyc = 0;
    req_valid = 1; req_write = we; req_word = word;
    req_addr = AW'(a); req_wdata = wd;
    while (k < 100) begin
      @(negedge clk); k++;
      if (req_ack) break;
    end
    got = req_rdata;
    req_valid = 0;
    chk(k == ops*LAT+1, "R7", "ack latency", k, ops*LAT+1);
    chk(ncyc == ops*LAT, "R7", "bus cycles", ncyc, ops*LAT);
    chk(nph == ops, rq, "operation count", nph, ops);
    chk(ph_addr[0] == AW'(a), rq, "first address", int'(ph_addr[0]), a);
    chk(ph_lo[0] == !odd, rq, "first lo_en", int'(ph_lo[0]), int'(!odd));
    chk(ph_hi[0] == (odd || word), rq, "first hi_en", int'(ph_hi[0]), int'(odd || word));
    if (!we) e_wd0 = 16'h0;
    else if (word && !odd) e_wd0 = wd;
    else if (odd) e_wd0 = {wd[7:0], 8'h00};
    else e_wd0 = {8'h00, wd[7:0]};
    chk(ph_wd[0] == e_wd0, "R8", "first write data", int'(ph_wd[0]), int'(e_wd0));
    if (spl && nph == 2) begin
      e_wd1 = we ? {8'h00, wd[15:8]} : 16'h0;
      chk(ph_addr[1] == AW'(a1), rq, "second address", int'(ph_addr[1]), a1);
      chk(ph_lo[1] && !ph_hi[1], rq, "second lanes", {ph_lo[1], ph_hi[1]}, 2);
      chk(ph_wd[1] == e_wd1, "R8", "second write data", int'(ph_wd[1]), int'(e_wd1));
    end
    if (!we) begin
      e_rd = word ? {ref_rd(a1), ref_rd(a)} : {8'h00, ref_rd(a)};
      chk(got == e_rd, rq, "read data", int'(got), int'(e_rd));
    end else begin
      refm[a] = wd[7:0];
      if (word) refm[a1] = wd[15:8];
    end
    @(negedge clk);
    chk(!req_ack, "R7", "ack width", int'(req_ack), 0);
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bases [4];
    bases = '{0, 'h40, 'h7FFF0, 'hFFFF0};
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk(!req_ack && !bus_cyc && !bus_lo_en && !bus_hi_en && bus_wdata == 0,
        "R1", "reset outputs", {req_ack, bus_cyc, bus_lo_en, bus_hi_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_cyc && !req_ack, "R1", "idle after reset", {bus_cyc, req_ack}, 0);
    do_req(1, 0, 'h100, 16'hFF3C);
    do_req(0, 0, 'h100, 16'h0);
    do_req(1, 0, 'h101, 16'hEEC5);
    do_req(0, 0, 'h101, 16'h0);
    do_req(0, 1, 'h100, 16'h0);
    do_req(1, 1, 'h200, 16'hBEEF);
    do_req(0, 1, 'h200, 16'h0);
    do_req(1, 1, 'h301, 16'h1234);
    do_req(0, 1, 'h301, 16'h0);
    do_req(0, 0, 'h302, 16'h0);
    do_req(1, 1, AMASK, 16'hA55A);
    do_req(0, 1, AMASK, 16'h0);
    do_req(0, 0, 0, 16'h0);
    for (int i = 0; i < 400; i++) begin
      int a = (bases[$urandom_range(3)] + $urandom_range(15)) & AMASK;
      do_req(1'($urandom_range(1)), 1'($urandom_range(1)), a, 16'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule